// File: doc/BRIEF.md
# Receive Buffer Ring Fetcher

This block walks a circular table of receive buffer records kept in system memory. Each record names one receive buffer with a 32-bit base address and a 32-bit size in 16-bit words. On command, the block reads the record under its read pointer one word at a time and loads the result into a current-buffer address register and a current-buffer word-count register. It then moves the read pointer forward by one record, wrapping it back to the ring start when it reaches the ring end.

Software places the ring in memory and programs the ring start, ring end, read and write pointers together with an upper-address register. Whenever the receive path needs a new buffer, it pulses the fetch command. When the advanced read pointer reaches the write pointer, the block raises a buffers-exhausted flag: the current buffer is then the last one software has made available. Software clears that flag by writing a one to it, and that same clear starts a fresh fetch. Each completed fetch also drops a hold flag that the receive path sets when its last buffer has filled, so reception can resume.

The bus width is a static mode input. In narrow mode each record field is one 16-bit slot. In wide mode each field takes a 32-bit slot and only its low half is used.

Top module: `rx_buf_ring_fetcher`

## Requirements
- R1: After reset, busy, memReq, exhaustFlag and rxHold are 0, and rdPtr, curBufAddr and curWordCnt are 0.
- R2: A write with regWrEn high stores regWrData in the register selected by regAddr: 0 upper address, 1 ring start, 2 ring end, 3 read pointer, 4 write pointer. The upper address is stored unchanged. The four ring pointers have bits 1:0 cleared when wideMode is 1, and bit 0 cleared when wideMode is 0. The read pointer can be seen on rdPtr.
- R3: A fetchCmd pulse while busy is low sets busy in the next cycle. Busy stays high until the fourth word of the record is accepted and falls at that clock edge. A fetchCmd that arrives while busy is high starts nothing.
- R4: The block requests one word at a time. It holds memReq high, with memAddr stable, until memAck. For word k (k = 0..3), memAddr is {upper address, rdPtr + k*S} modulo 2^16 in the low half, where S is 2 when wideMode is 0 and 4 when wideMode is 1.
- R5: Word 0 goes to curBufAddr[15:0], word 1 to curBufAddr[31:16], word 2 to curWordCnt[15:0] and word 3 to curWordCnt[31:16]. All four are visible when busy falls.
- R6: At the edge where busy falls, rdPtr advances by 8 when wideMode is 0 and by 16 when wideMode is 1, modulo 2^16. When no fetch is running and no register is written, rdPtr keeps its value.
- R7: If the advanced pointer equals the ring end, rdPtr is loaded with the ring start instead.
- R8: If the final rdPtr equals the write pointer, exhaustFlag is set at the edge where busy falls. Otherwise the flag keeps its value.
- R9: An exhaustClr pulse while exhaustFlag is 1 clears the flag and, if busy is low, starts a fetch exactly as fetchCmd does. An exhaustClr pulse while exhaustFlag is 0 has no effect.
- R10: An rxHoldSet pulse sets rxHold. The edge where busy falls clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wideMode | input | 1 | Static bus width mode: 1 for 32-bit slots, 0 for 16-bit slots |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 3 | Register select for writes |
| regWrData | input | 16 | Register write data |
| fetchCmd | input | 1 | Read-resource command pulse |
| exhaustClr | input | 1 | Write-one-to-clear pulse for the exhausted flag |
| rxHoldSet | input | 1 | Receive path reports that its last buffer is full |
| memReq | output | 1 | Word read request |
| memAddr | output | 32 | Byte address of the requested word |
| memAck | input | 1 | Read acknowledge; memRdData is valid with it |
| memRdData | input | 16 | Read data |
| busy | output | 1 | Fetch in progress |
| rdPtr | output | 16 | Current ring read pointer |
| curBufAddr | output | 32 | Current buffer base address |
| curWordCnt | output | 32 | Current buffer size in words |
| exhaustFlag | output | 1 | Buffers-exhausted interrupt flag |
| rxHold | output | 1 | Last-buffer-full hold flag |

## Verification
The fetch is tried in both width modes, against a memory whose words are a function of their address. Any misplaced lane, offset or upper-address bit therefore shows up as a wrong word or a wrong request address. The narrow run steps through a plain advance, an advance that lands on the write pointer, a clear-triggered fetch and an advance that wraps at the ring end. These separate the advance, exhaust and wrap paths from one another. The wide run starts near the top of the 16-bit space, so the in-record offsets overflow and the wrap fires on the overflowed value. Further cases cover a command sent in the middle of a fetch, a clear sent with the flag already low, and unaligned pointer writes; these show whether stray triggers are ignored and whether the low address bits are masked.

// File: rtl/rbr_pkg.sv
package rbr_pkg;
  localparam int RecWords = 4;
  localparam int IdxW = $clog2(RecWords);

  typedef struct packed {
    logic            start;
    logic            loadWord;
    logic [IdxW-1:0] wordIdx;
    logic            finish;
  } rbrCtlT;
endpackage

// File: rtl/rbr_ctrl.sv
module rbr_ctrl
  import rbr_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   fetchCmd,
  input  logic   exhaustClr,
  input  logic   exhaustFlag,
  input  logic   memAck,
  output logic   busy,
  output rbrCtlT ctl
);
  localparam logic [IdxW-1:0] LastIdx = IdxW'(RecWords - 1);

  logic busyQ;
  logic [IdxW-1:0] idxQ;
  logic startReq;

  // a clear of a flag that is already low is no trigger
  assign startReq = !busyQ && (fetchCmd || (exhaustClr && exhaustFlag));

  always_comb begin
    ctl.start    = startReq;
    ctl.loadWord = busyQ && memAck;
    ctl.wordIdx  = idxQ;
    ctl.finish   = busyQ && memAck && (idxQ == LastIdx);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyQ <= 1'b0;
      idxQ  <= '0;
    end else if (startReq) begin
      busyQ <= 1'b1;
      idxQ  <= '0;
    end else if (busyQ && memAck) begin
      idxQ <= idxQ + 1'b1;
      if (idxQ == LastIdx) busyQ <= 1'b0;
    end
  end

  assign busy = busyQ;
endmodule

// File: rtl/rbr_datapath.sv
module rbr_datapath
  import rbr_pkg::*;
#(
  parameter int PTR_W = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wideMode,
  input  logic               regWrEn,
  input  logic [2:0]         regAddr,
  input  logic [PTR_W-1:0]   regWrData,
  input  logic               exhaustClr,
  input  logic               rxHoldSet,
  input  logic [PTR_W-1:0]   memRdData,
  input  rbrCtlT             ctl,
  output logic [2*PTR_W-1:0] memAddr,
  output logic [PTR_W-1:0]   rdPtr,
  output logic [2*PTR_W-1:0] curBufAddr,
  output logic [2*PTR_W-1:0] curWordCnt,
  output logic               exhaustFlag,
  output logic               rxHold
);
  localparam logic [2:0] SelUpper = 3'd0;
  localparam logic [2:0] SelStart = 3'd1;
  localparam logic [2:0] SelEnd   = 3'd2;
  localparam logic [2:0] SelRead  = 3'd3;
  localparam logic [2:0] SelWrite = 3'd4;
  localparam int NarrowSlot = 2;
  localparam int WideSlot   = 4;

  logic [PTR_W-1:0] upperQ, startQ, endQ, rdQ, wrQ;
  logic [PTR_W-1:0] alignMask, wrAligned;
  logic [PTR_W-1:0] wordOfs, recBytes, stepped, wrapped;
  logic [PTR_W-1:0] bufLoQ, bufHiQ, cntLoQ, cntHiQ;
  logic flagQ, holdQ;

  assign alignMask = wideMode ? ~PTR_W'(WideSlot - 1) : ~PTR_W'(NarrowSlot - 1);
  assign wrAligned = regWrData & alignMask;

  assign wordOfs  = wideMode ? PTR_W'(ctl.wordIdx) * PTR_W'(WideSlot)
                             : PTR_W'(ctl.wordIdx) * PTR_W'(NarrowSlot);
  assign recBytes = wideMode ? PTR_W'(RecWords * WideSlot) : PTR_W'(RecWords * NarrowSlot);
  assign stepped  = rdQ + recBytes;
  assign wrapped  = (stepped == endQ) ? startQ : stepped;
  assign memAddr  = {upperQ, rdQ + wordOfs};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      upperQ <= '0;
      startQ <= '0;
      endQ   <= '0;
      rdQ    <= '0;
      wrQ    <= '0;
    end else begin
      if (regWrEn) begin
        case (regAddr)
          SelUpper: upperQ <= regWrData;
          SelStart: startQ <= wrAligned;
          SelEnd:   endQ   <= wrAligned;
          SelRead:  rdQ    <= wrAligned;
          SelWrite: wrQ    <= wrAligned;
          default: ;
        endcase
      end
      // the advance of a completing fetch wins over a same-cycle pointer write
      if (ctl.finish) rdQ <= wrapped;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bufLoQ <= '0;
      bufHiQ <= '0;
      cntLoQ <= '0;
      cntHiQ <= '0;
    end else if (ctl.loadWord) begin
      case (ctl.wordIdx)
        IdxW'(0): bufLoQ <= memRdData;
        IdxW'(1): bufHiQ <= memRdData;
        IdxW'(2): cntLoQ <= memRdData;
        default:  cntHiQ <= memRdData;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      flagQ <= 1'b0;
      holdQ <= 1'b0;
    end else begin
      if (ctl.finish && (wrapped == wrQ)) flagQ <= 1'b1;
      else if (exhaustClr)                flagQ <= 1'b0;
      if (ctl.finish)     holdQ <= 1'b0;
      else if (rxHoldSet) holdQ <= 1'b1;
    end
  end

  assign rdPtr       = rdQ;
  assign curBufAddr  = {bufHiQ, bufLoQ};
  assign curWordCnt  = {cntHiQ, cntLoQ};
  assign exhaustFlag = flagQ;
  assign rxHold      = holdQ;
endmodule

// File: rtl/rx_buf_ring_fetcher.sv
module rx_buf_ring_fetcher
  import rbr_pkg::*;
#(
  parameter int PTR_W = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wideMode,
  input  logic               regWrEn,
  input  logic [2:0]         regAddr,
  input  logic [PTR_W-1:0]   regWrData,
  input  logic               fetchCmd,
  input  logic               exhaustClr,
  input  logic               rxHoldSet,
  output logic               memReq,
  output logic [2*PTR_W-1:0] memAddr,
  input  logic               memAck,
  input  logic [PTR_W-1:0]   memRdData,
  output logic               busy,
  output logic [PTR_W-1:0]   rdPtr,
  output logic [2*PTR_W-1:0] curBufAddr,
  output logic [2*PTR_W-1:0] curWordCnt,
  output logic               exhaustFlag,
  output logic               rxHold
);
  rbrCtlT ctl;
  logic busyInt;

  rbr_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .fetchCmd(fetchCmd), .exhaustClr(exhaustClr),
    .exhaustFlag(exhaustFlag), .memAck(memAck), .busy(busyInt), .ctl(ctl)
  );

  rbr_datapath #(.PTR_W(PTR_W)) u_dp (
    .clk(clk), .rstN(rstN), .wideMode(wideMode), .regWrEn(regWrEn),
    .regAddr(regAddr), .regWrData(regWrData), .exhaustClr(exhaustClr),
    .rxHoldSet(rxHoldSet), .memRdData(memRdData), .ctl(ctl),
    .memAddr(memAddr), .rdPtr(rdPtr), .curBufAddr(curBufAddr),
    .curWordCnt(curWordCnt), .exhaustFlag(exhaustFlag), .rxHold(rxHold)
  );

  assign busy   = busyInt;
  assign memReq = busyInt;
endmodule

// File: rtl/rbr_checker.sv
module rbr_checker #(
  parameter int PTR_W = 16
) (
  input logic               clk,
  input logic               rstN,
  input logic               regWrEn,
  input logic               fetchCmd,
  input logic               exhaustClr,
  input logic               memReq,
  input logic [2*PTR_W-1:0] memAddr,
  input logic               memAck,
  input logic               busy,
  input logic [PTR_W-1:0]   rdPtr,
  input logic               exhaustFlag,
  input logic               rxHold
);
  // R4: a request stays up with a steady address until acknowledged
  p_req_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memAck |=> memReq && $stable(memAddr));

  // R3: a fetch only begins after a trigger
  p_busy_start_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(fetchCmd || exhaustClr));

  // R8: the flag only rises as a fetch completes
  p_flag_set_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(exhaustFlag) |-> $fell(busy));

  // R2: the read pointer is always at least 2-byte aligned
  p_align_r2: assert property (@(posedge clk) disable iff (!rstN)
    rdPtr[0] == 1'b0);

  // R6: the pointer is steady while idle with no register write
  p_ptr_stable_r6: assert property (@(posedge clk) disable iff (!rstN)
    !busy && !regWrEn |=> $stable(rdPtr));

  // R10: completion leaves the hold flag low
  p_hold_clear_r10: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> !rxHold);
endmodule

bind rx_buf_ring_fetcher rbr_checker #(.PTR_W(PTR_W)) u_chk (
  .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .fetchCmd(fetchCmd),
  .exhaustClr(exhaustClr), .memReq(memReq), .memAddr(memAddr),
  .memAck(memAck), .busy(busy), .rdPtr(rdPtr), .exhaustFlag(exhaustFlag),
  .rxHold(rxHold)
);

// File: tb/tb_rx_buf_ring_fetcher.sv
`timescale 1ns/1ps
module tb_rx_buf_ring_fetcher;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wideMode = 1'b0;
  logic regWrEn = 1'b0;
  logic [2:0] regAddr = '0;
  logic [15:0] regWrData = '0;
  logic fetchCmd = 1'b0, exhaustClr = 1'b0, rxHoldSet = 1'b0;
  logic memReq, memAck = 1'b0;
  logic [31:0] memAddr;
  logic [15:0] memRdData = '0;
  logic busy, exhaustFlag, rxHold;
  logic [15:0] rdPtr;
  logic [31:0] curBufAddr, curWordCnt;

  int checks = 0, errors = 0, lat = 0;
  bit finished = 0;

  typedef struct {
    logic [31:0] bufA;
    logic [31:0] cnt;
    logic [15:0] ptr;
    logic        flag;
  } expT;

  expT resQ[$];
  logic [31:0] addrQ[$];

  logic [15:0] mUpper, mStart, mEnd, mRd, mWr;
  logic mFlag;

  always #5 clk = ~clk;

  rx_buf_ring_fetcher dut (
    .clk(clk), .rstN(rstN), .wideMode(wideMode), .regWrEn(regWrEn),
    .regAddr(regAddr), .regWrData(regWrData), .fetchCmd(fetchCmd),
    .exhaustClr(exhaustClr), .rxHoldSet(rxHoldSet), .memReq(memReq),
    .memAddr(memAddr), .memAck(memAck), .memRdData(memRdData), .busy(busy),
    .rdPtr(rdPtr), .curBufAddr(curBufAddr), .curWordCnt(curWordCnt),
    .exhaustFlag(exhaustFlag), .rxHold(rxHold)
  );

  function automatic logic [15:0] memWord(logic [31:0] a);
    return a[15:0] ^ 16'h5A3C ^ {a[23:16], a[31:24]};
  endfunction

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // memory responder and request-address monitor
  initial begin
    int cnt = 0;
    forever begin
      @(negedge clk);
      memAck = 1'b0;
      if (memReq) begin
        if (cnt >= lat) begin
          cnt = 0;
          if (addrQ.size() == 0) chk(0, "R3 extra read", memAddr, 0);
          else begin
            logic [31:0] e;
            e = addrQ.pop_front();
            chk(memAddr == e, "R4 request address", memAddr, e);
          end
          memRdData = memWord(memAddr);
          memAck = 1'b1;
        end else cnt++;
      end else cnt = 0;
    end
  end

  // result monitor
  initial begin
    logic prevBusy = 1'b0;
    forever begin
      @(negedge clk);
      if (prevBusy && !busy) begin
        if (resQ.size() == 0) chk(0, "R3 unexpected completion", 1, 0);
        else begin
          expT e;
          e = resQ.pop_front();
          chk(curBufAddr == e.bufA, "R5 buffer address", curBufAddr, e.bufA);
          chk(curWordCnt == e.cnt, "R5 word count", curWordCnt, e.cnt);
          chk(rdPtr == e.ptr, "R6/R7 read pointer", rdPtr, e.ptr);
          chk(exhaustFlag == e.flag, "R8 exhausted flag", exhaustFlag, e.flag);
          chk(rxHold == 1'b0, "R10 hold cleared", rxHold, 0);
        end
      end
      prevBusy = busy;
    end
  end

  task automatic doReset(bit wide);
    @(negedge clk);
    rstN = 1'b0;
    wideMode = wide;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    mUpper = 0; mStart = 0; mEnd = 0; mRd = 0; mWr = 0; mFlag = 0;
    @(negedge clk);
  endtask

  task automatic writeReg(logic [2:0] a, logic [15:0] d);
    logic [15:0] m;
    m = wideMode ? (d & 16'hFFFC) : (d & 16'hFFFE);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
    case (a)
      3'd0: mUpper = d;
      3'd1: mStart = m;
      3'd2: mEnd = m;
      3'd3: mRd = m;
      3'd4: mWr = m;
      default: ;
    endcase
  endtask

  // trig 0: fetchCmd, 1: exhaustClr
  task automatic doFetch(bit trig, bit extraCmd);
    expT e;
    logic [15:0] slot, w[4], nxt;
    slot = wideMode ? 16'd4 : 16'd2;
    for (int k = 0; k < 4; k++) begin
      logic [31:0] a;
      a = {mUpper, mRd + 16'(k) * slot};
      addrQ.push_back(a);
      w[k] = memWord(a);
    end
    if (trig) mFlag = 1'b0;
    nxt = mRd + 4 * slot;
    if (nxt == mEnd) nxt = mStart;
    mRd = nxt;
    if (mRd == mWr) mFlag = 1'b1;
    e.bufA = {w[1], w[0]};
    e.cnt = {w[3], w[2]};
    e.ptr = mRd;
    e.flag = mFlag;
    resQ.push_back(e);
    if (trig) exhaustClr = 1'b1; else fetchCmd = 1'b1;
    @(negedge clk);
    exhaustClr = 1'b0; fetchCmd = 1'b0;
    chk(busy == 1'b1, "R3 busy after trigger", busy, 1);
    if (extraCmd) begin
      @(negedge clk);
      fetchCmd = 1'b1;
      @(negedge clk);
      fetchCmd = 1'b0;
    end
    while (busy) @(negedge clk);
    if (extraCmd) begin
      repeat (3) @(negedge clk);
      chk(busy == 1'b0, "R3 command during fetch ignored", busy, 0);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    doReset(0);
    // R1 reset state
    chk(busy == 0, "R1 busy", busy, 0);
    chk(memReq == 0, "R1 memReq", memReq, 0);
    chk(exhaustFlag == 0, "R1 exhaustFlag", exhaustFlag, 0);
    chk(rxHold == 0, "R1 rxHold", rxHold, 0);
    chk(rdPtr == 0, "R1 rdPtr", rdPtr, 0);
    chk(curBufAddr == 0, "R1 curBufAddr", curBufAddr, 0);
    chk(curWordCnt == 0, "R1 curWordCnt", curWordCnt, 0);

    // narrow mode ring: 4 records from 0x0100 to 0x0120
    writeReg(3'd0, 16'h0012);
    writeReg(3'd1, 16'h0100);
    writeReg(3'd2, 16'h0120);
    writeReg(3'd3, 16'h0101);
    chk(rdPtr == 16'h0100, "R2 narrow alignment", rdPtr, 16'h0100);
    writeReg(3'd4, 16'h0110);
    lat = 0;
    doFetch(0, 0);                       // plain advance to 0x0108
    lat = 2;
    doFetch(0, 0);                       // lands on write pointer, R8
    rxHoldSet = 1'b1;
    @(negedge clk);
    rxHoldSet = 1'b0;
    chk(rxHold == 1'b1, "R10 hold set", rxHold, 1);
    lat = 1;
    doFetch(1, 0);                       // R9 clear-triggered fetch
    doFetch(0, 0);                       // R7 wrap to start
    // R9 clear with flag low does nothing
    exhaustClr = 1'b1;
    @(negedge clk);
    exhaustClr = 1'b0;
    repeat (4) @(negedge clk);
    chk(busy == 0, "R9 clear with flag low starts nothing", busy, 0);
    chk(rdPtr == mRd, "R9 pointer unchanged", rdPtr, mRd);
    lat = 0;
    doFetch(0, 1);                       // R3 extra command mid-fetch

    // wide mode near the top of the offset space
    doReset(1);
    writeReg(3'd0, 16'hABCD);
    writeReg(3'd1, 16'hFFC2);
    chk(rdPtr == 16'h0000, "R2 start write leaves read pointer", rdPtr, 0);
    writeReg(3'd2, 16'h0006);
    writeReg(3'd3, 16'hFFF6);
    chk(rdPtr == 16'hFFF4, "R2 wide alignment", rdPtr, 16'hFFF4);
    writeReg(3'd4, 16'hFFD0);
    lat = 1;
    doFetch(0, 0);                       // R4 offset overflow, R7 wrap at 0x0004
    doFetch(0, 0);                       // reaches write pointer, R8
    lat = 0;
    doFetch(0, 0);                       // flag stays set, R8
    repeat (3) @(negedge clk);
    chk(resQ.size() == 0, "R3 all fetches completed", resQ.size(), 0);
    chk(addrQ.size() == 0, "R4 all reads issued", addrQ.size(), 0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule